// File: doc/BRIEF.md
# Masked Alarm and Shutdown Monitor

This block takes a ten-bit vector of error events, which detectors elsewhere on the chip raise, and turns it into two results. The first is an alarm on an open-drain, bidirectional alarm pin. A polarity bit picks whether the pin is pulled low or released while the alarm is active. A three-bit code sets a minimum indication time, so that a short event is still seen on the pin. The second result is a registered request that asks the output line drivers to shut down.

Two independent ten-bit masks choose which events reach the alarm and which reach the shutdown request. Bit 4 has a special meaning in each mask. In the alarm mask it routes the ungated index enable to the pin, which is used when setting up the index position. In the shutdown mask it treats the alarm pin, read back through a synchronizer, as an external system error whenever another device holds the pin low. The block also passes through an enable for an internal pull-up source on the pin.

The indication time is counted in units of `TICK_CYCLES` clock cycles; the default corresponds to 12.5 ms at 125 MHz. Each newly raised masked alarm event restarts the timer.

Top module: `alarm_shutdown_monitor`

## Requirements
- R1: Event bits 0, 1, 2, 3, 5, 7 and 8 of `evt_i` make the alarm active, combinationally, whenever the same bit of `amask_i` is 1.
- R2: Event bits 6 and 9 are unused. They reach neither the alarm nor the shutdown request, whatever the masks hold.
- R3: Bit 4 of `evt_i` is ignored. When `amask_i[4]` is 1, the alarm is active whenever `idx_en_i` is 1.
- R4: With `pol_i` = 0, `pin_pd_o` is 1 exactly when the alarm is active. With `pol_i` = 1, `pin_pd_o` is 1 exactly when the alarm is inactive.
- R5: `shut_o` equals the OR of `evt_i & smask_i` over the used bits, as sampled at the previous rising clock edge.
- R6: With `pol_i` = 0 and `smask_i[4]` = 1, a low on `pin_in_i` raises `shut_o` at the third rising edge after the change (two synchronizer stages and one output register), and not before. With `pol_i` = 1, a low on `pin_in_i` never raises `shut_o`.
- R7: A masked alarm event whose bit was 0 at the previous edge is captured at the next rising edge. The alarm then stays active for exactly `hold_code_i` × `TICK_CYCLES` cycles after that edge, or for as long as a masked event is present, whichever ends later.
- R8: A new masked event that arrives while the timer is running restarts the full interval from its own capture edge.
- R9: With `hold_code_i` = 0, `pin_pd_o` follows the masked events and `idx_en_i` in the same cycle, with no delay.
- R10: `pin_pu_o` always equals `pu_en_cfg_i`.
- R11: During reset and right after it, with no events applied, the timer is idle and `shut_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | Error event vector |
| amask_i | input | 10 | Mask selecting the events that reach the alarm; bit 4 routes the index enable |
| smask_i | input | 10 | Mask selecting the events that reach the shutdown request; bit 4 senses the pin being held low |
| pol_i | input | 1 | Pin polarity: 0 pulls the pin low on alarm, 1 releases the pin on alarm |
| hold_code_i | input | CODE_W | Minimum indication time, in units of TICK_CYCLES cycles |
| idx_en_i | input | 1 | Ungated index enable |
| pin_in_i | input | 1 | Readback of the alarm pin level |
| pu_en_cfg_i | input | 1 | Request for the internal pull-up |
| pin_pd_o | output | 1 | Pull-down enable for the open-drain alarm pin |
| pin_pu_o | output | 1 | Pull-up source enable |
| shut_o | output | 1 | Line-driver shutdown request |

## Verification
The hardest case to reach from the ports is a second event that arrives while the indication countdown is already running. The first event has to be released, some timer units have to elapse, and only then must a different masked bit rise; the check is that the full interval starts again from that later edge. The bench overrides `TICK_CYCLES` with a small value so that whole intervals fit into a few dozen cycles. It then counts, cycle by cycle, how long the pin stays asserted after the release, for several codes, for a retriggered sequence, and for an event that is held longer than its interval. The three-edge latency of the pin readback is checked on both sides of its boundary.

// File: rtl/asm_pkg.sv
package asm_pkg;
  localparam int unsigned EVT_W   = 10;
  localparam int unsigned IDX_BIT = 4;
  // bits 0,1,2,3,5,7,8 carry real events; 4 is special, 6 and 9 unused
  localparam logic [EVT_W-1:0] EVT_USED = 10'b01_1010_1111;

  typedef enum logic {
    POL_LOW_ON_ERR     = 1'b0,
    POL_RELEASE_ON_ERR = 1'b1
  } alarm_pol_e;

  function automatic logic [EVT_W-1:0] gate_events(
    input logic [EVT_W-1:0] evt,
    input logic [EVT_W-1:0] mask,
    input logic             special
  );
    logic [EVT_W-1:0] v;
    v          = evt & EVT_USED;
    v[IDX_BIT] = special;
    return v & mask;
  endfunction

  function automatic logic pd_drive(input logic active, input alarm_pol_e pol);
    return (pol == POL_RELEASE_ON_ERR) ? ~active : active;
  endfunction
endpackage

// File: rtl/asm_sync.sv
module asm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b1;
        else        r <= d_i;
      end
      assign q_o = r;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d_i};
      end
      assign q_o = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/asm_hold_timer.sv
module asm_hold_timer #(
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned TICK_CYCLES = 1_562_500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] cnt_o,
  output logic              busy_o
);
  localparam int unsigned PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0]  pre;
  logic [CODE_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pre <= '0;
    end else if (load_i) begin
      cnt <= code_i;
      pre <= '0;
    end else if (cnt != '0) begin
      if (pre == PRE_LAST) begin
        pre <= '0;
        cnt <= cnt - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign cnt_o  = cnt;
  assign busy_o = (cnt != '0);
endmodule

// File: rtl/asm_shut_reg.sv
module asm_shut_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vec_i,
  output logic         any_o,
  output logic         shut_o
);
  assign any_o = |vec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shut_o <= 1'b0;
    else        shut_o <= any_o;
  end
endmodule

// File: rtl/alarm_shutdown_monitor.sv
module alarm_shutdown_monitor
  import asm_pkg::*;
#(
  parameter int unsigned CODE_W      = 3,
  parameter int unsigned TICK_CYCLES = 1_562_500,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [EVT_W-1:0]  amask_i,
  input  logic [EVT_W-1:0]  smask_i,
  input  logic              pol_i,
  input  logic [CODE_W-1:0] hold_code_i,
  input  logic              idx_en_i,
  input  logic              pin_in_i,
  input  logic              pu_en_cfg_i,
  output logic              pin_pd_o,
  output logic              pin_pu_o,
  output logic              shut_o
);
  // named internal events, brought out for the checker
  logic [EVT_W-1:0]  alarm_vec;
  logic [EVT_W-1:0]  alarm_vec_q;
  logic [EVT_W-1:0]  shut_vec;
  logic              alarm_new;
  logic              alarm_raw;
  logic              alarm_act;
  logic              hold_busy;
  logic [CODE_W-1:0] hold_cnt;
  logic              pin_sync;
  logic              pin_low_err;
  logic              shut_any;
  alarm_pol_e        pol;

  assign pol = alarm_pol_e'(pol_i);

  asm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in_i),
    .q_o   (pin_sync)
  );

  // an external low only counts as a system error in low-on-error polarity
  assign pin_low_err = ~pin_sync & (pol == POL_LOW_ON_ERR);

  assign alarm_vec = gate_events(evt_i, amask_i, idx_en_i);
  assign shut_vec  = gate_events(evt_i, smask_i, pin_low_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_vec_q <= '0;
    else        alarm_vec_q <= alarm_vec;
  end

  assign alarm_new = |(alarm_vec & ~alarm_vec_q);
  assign alarm_raw = |alarm_vec;

  asm_hold_timer #(.CODE_W(CODE_W), .TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (alarm_new),
    .code_i (hold_code_i),
    .cnt_o  (hold_cnt),
    .busy_o (hold_busy)
  );

  assign alarm_act = alarm_raw | hold_busy;
  assign pin_pd_o  = pd_drive(alarm_act, pol);
  assign pin_pu_o  = pu_en_cfg_i;

  asm_shut_reg #(.W(EVT_W)) u_shut (
    .clk    (clk),
    .rst_n  (rst_n),
    .vec_i  (shut_vec),
    .any_o  (shut_any),
    .shut_o (shut_o)
  );
endmodule

// File: rtl/asm_checker.sv
module asm_checker #(
  parameter int unsigned CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pol_i,
  input logic [CODE_W-1:0] hold_code_i,
  input logic              pin_pd_o,
  input logic              shut_o,
  input logic              alarm_act,
  input logic              alarm_new,
  input logic              alarm_raw,
  input logic [CODE_W-1:0] hold_cnt,
  input logic              shut_any,
  input logic              pin_low_err
);
  AST_SHUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    shut_any |=> shut_o); // R5
  AST_SHUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_any |=> !shut_o); // R5
  AST_POL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pol_i && alarm_act) |-> pin_pd_o); // R4
  AST_POL_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_i && alarm_act) |-> !pin_pd_o); // R4
  AST_RAW_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_raw |-> alarm_act); // R1
  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_new && hold_code_i != '0) |=> alarm_act); // R7
  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_new |=> (hold_cnt <= $past(hold_cnt))); // R8
  AST_PIN_POL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    pol_i |-> !pin_low_err); // R6
endmodule

bind alarm_shutdown_monitor asm_checker #(.CODE_W(CODE_W)) u_asm_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pol_i       (pol_i),
  .hold_code_i (hold_code_i),
  .pin_pd_o    (pin_pd_o),
  .shut_o      (shut_o),
  .alarm_act   (alarm_act),
  .alarm_new   (alarm_new),
  .alarm_raw   (alarm_raw),
  .hold_cnt    (hold_cnt),
  .shut_any    (shut_any),
  .pin_low_err (pin_low_err)
);

// File: tb/alarm_shutdown_monitor_bench.sv
module alarm_shutdown_monitor_bench;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned TICK   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] evt = '0, amask = '0, smask = '0;
  logic pol = 1'b0, idx = 1'b0, pin = 1'b1, pu = 1'b0;
  logic [CODE_W-1:0] code = '0;
  logic pd, pu_o, shut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  alarm_shutdown_monitor #(.CODE_W(CODE_W), .TICK_CYCLES(TICK), .SYNC_STAGES(2))
  u_alarm_shutdown_monitor (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .amask_i(amask), .smask_i(smask),
    .pol_i(pol), .hold_code_i(code), .idx_en_i(idx), .pin_in_i(pin),
    .pu_en_cfg_i(pu), .pin_pd_o(pd), .pin_pu_o(pu_o), .shut_o(shut)
  );

  // requirement-level model: list the meaningful bits explicitly
  function automatic bit used_bit(input int b);
    case (b)
      0, 1, 2, 3, 5, 7, 8: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction

  function automatic bit exp_alarm(input logic [9:0] e, input logic [9:0] m, input logic ix);
    bit r = 1'b0;
    for (int b = 0; b < 10; b++) if (used_bit(b) && e[b] && m[b]) r = 1'b1;
    if (m[4] && ix) r = 1'b1;
    return r;
  endfunction

  function automatic bit exp_shut(input logic [9:0] e, input logic [9:0] m);
    bit r = 1'b0;
    for (int b = 0; b < 10; b++) if (used_bit(b) && e[b] && m[b]) r = 1'b1;
    return r;
  endfunction

  function automatic bit exp_pd(input bit act, input logic p);
    return p ? !act : act;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    evt = '0; idx = 1'b0;
    repeat (n) step();
  endtask

  // count consecutive cycles the pin stays asserted (pol 0)
  task automatic count_active(output int n);
    n = 0;
    for (int k = 0; k < 80; k++) begin
      #1;
      if (pd !== 1'b1) break;
      n++;
      step();
    end
  endtask

  initial begin
    int n;
    bit e_sh;
    void'($urandom(32'd20240611));
    #20;
    #1 chk(shut === 1'b0, "R11 shut in reset", shut, 0);
    chk(pd === 1'b0, "R11 pin idle in reset", pd, 0);
    step(); rst_n = 1'b1;
    step(); step(); #1;
    chk(shut === 1'b0, "R11 shut after reset", shut, 0);
    chk(pd === 1'b0, "R11 no alarm after reset", pd, 0);

    // R10 pull-up passthrough
    pu = 1'b1; #1 chk(pu_o === 1'b1, "R10 pull-up on", pu_o, 1);
    pu = 1'b0; #1 chk(pu_o === 1'b0, "R10 pull-up off", pu_o, 0);

    // R4 polarity 1 with no alarm: pin pulled low
    pol = 1'b1; #1 chk(pd === 1'b1, "R4 release polarity idle", pd, 1);
    pol = 1'b0; #1 chk(pd === 1'b0, "R4 low polarity idle", pd, 0);

    // random phase, code 0: combinational alarm and registered shutdown
    step();
    for (int it = 0; it < 80; it++) begin
      evt = 10'($urandom); amask = 10'($urandom); smask = 10'($urandom);
      pol = 1'($urandom); idx = 1'($urandom); code = '0; pin = 1'b1;
      #1;
      chk(pd === exp_pd(exp_alarm(evt, amask, idx), pol), "R9 R1 R3 R4 random alarm",
          pd, exp_pd(exp_alarm(evt, amask, idx), pol));
      e_sh = exp_shut(evt, smask);
      step(); #1;
      chk(shut === e_sh, "R5 random shutdown", shut, e_sh);
    end
    pol = 1'b0; idle(4);

    // R2 unused bits
    evt = 10'h240; amask = '1; smask = 10'h3EF; #1;
    chk(pd === 1'b0, "R2 unused bits alarm", pd, 0);
    step(); #1 chk(shut === 1'b0, "R2 unused bits shutdown", shut, 0);

    // R3 event bit 4 ignored, index enable routed
    evt = 10'h010; amask = '1; smask = 10'h3EF; idx = 1'b0; #1;
    chk(pd === 1'b0, "R3 evt bit4 ignored", pd, 0);
    step(); #1 chk(shut === 1'b0, "R3 evt bit4 no shutdown", shut, 0);
    evt = '0; amask = 10'h010; idx = 1'b1; #1;
    chk(pd === 1'b1, "R9 pin follows index high", pd, 1);
    idx = 1'b0; #1 chk(pd === 1'b0, "R9 pin follows index low", pd, 0);
    smask = '0; idle(3);

    // R6 pin readback latency, polarity 0
    amask = '0; smask = 10'h010; pol = 1'b0;
    pin = 1'b0;
    step(); step(); #1 chk(shut === 1'b0, "R6 not before third edge", shut, 0);
    step(); #1 chk(shut === 1'b1, "R6 external low at third edge", shut, 1);
    pin = 1'b1; idle(4);
    // R6 polarity 1 ignores pin
    pol = 1'b1; pin = 1'b0; idle(6); #1;
    chk(shut === 1'b0, "R6 ignored with polarity 1", shut, 0);
    pin = 1'b1; pol = 1'b0; smask = '0; idle(4);

    // R7 minimum indication time for several codes
    amask = '1;
    for (int c = 0; c < 6; c += 3) begin
      code = CODE_W'(c);
      evt = 10'h001; step(); evt = '0;
      count_active(n);
      chk(n == c * TICK, "R7 stretch length", n, c * TICK);
      idle(40);
    end
    code = 3'd5; evt = 10'h002; step(); evt = '0;
    count_active(n);
    chk(n == 5 * TICK, "R7 stretch code 5", n, 5 * TICK);
    idle(40);

    // R7 event held longer than interval: release ends alarm at once
    code = 3'd1; evt = 10'h080; repeat (10) step();
    #1 chk(pd === 1'b1, "R7 active while event held", pd, 1);
    evt = '0; count_active(n);
    chk(n == 0, "R7 expired timer after long event", n, 0);
    idle(10);

    // R8 retrigger restarts the full interval
    code = 3'd2;
    evt = 10'h001; step(); evt = '0; repeat (3) step();
    evt = 10'h002; step(); evt = '0;
    count_active(n);
    chk(n == 2 * TICK, "R8 retrigger length", n, 2 * TICK);
    idle(20);

    // R4 polarity 1 while stretching: pin released
    code = 3'd2; pol = 1'b1;
    evt = 10'h020; step(); evt = '0; #1;
    chk(pd === 1'b0, "R4 released during stretch", pd, 0);
    idle(20); #1;
    chk(pd === 1'b1, "R4 pulled low after stretch", pd, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule